// File: doc/BRIEF.md
# Graded Carry-Select Adder

A purely combinational unsigned adder that adds two operands of a configurable width plus a single carry-in. It produces the sum and a carry-out. The operand bits are cut into consecutive blocks, and the blocks get wider toward the most significant end.

The lowest block is a plain ripple adder that takes the real carry-in. Every other block holds two ripple adders that run at the same time, one built for an incoming carry of 0 and one for an incoming carry of 1. The true carry from the block below then drives a 2:1 selector that picks one of the two sums and one of the two carry-outs. Because the blocks grow in width, a wider upper block has more time to finish its two ripple chains before its select carry arrives through the chain of selectors. The adder sits in a datapath between registers that belong to the user.

The block widths are a parameter, listed from the least significant block upward. The default is a 64-bit adder with widths 7, 7, 8, 9, 10, 11 and 12. Elaboration stops with an error if the widths do not add up to the operand width.

Top module: `csa_graded_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of the arithmetic sum opa + opb + cin, with both operands taken as unsigned, for every input combination.
- R2: `cout` equals bit WIDTH (the overflow bit) of the same (WIDTH+1)-bit arithmetic sum, so the top block's selected carry is the carry of the full addition.
- R3: With opa all ones, opb zero and cin 1, `sum` is zero and `cout` is 1. The incoming carry crosses every block boundary.
- R4: When the operand bits below a block boundary all propagate (opa XOR opb all ones there) and cin is 1, the sum bit at the boundary equals opa XOR opb XOR 1 at that position. The selector of that block picks its carry-of-1 result.
- R5: For fixed operands, raising cin from 0 to 1 raises the (WIDTH+1)-bit result {cout, sum} by exactly one, modulo 2^(WIDTH+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First unsigned operand |
| opb | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Low WIDTH bits of opa + opb + cin |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The case that is hardest to reach from the ports is a carry that starts at cin and has to pass through the selector of every block. This needs every lower bit to be in propagate state. Random operands almost never produce it, so the stimulus builds it on purpose: at each block boundary the operands are set to all ones below it, and cin is switched between 0 and 1. A small 8-bit instance with three unequal blocks is also swept exhaustively over both operands and both carry values. That sweep covers every kill, generate and propagate pattern at each boundary.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Width of one entry of the block-size list
    localparam int SZ_W       = 8;
    // Largest number of blocks the list can describe
    localparam int MAX_BLOCKS = 16;

    // Entry i (least significant block first) sits at bits [i*SZ_W +: SZ_W]
    typedef logic [MAX_BLOCKS*SZ_W-1:0] size_list_t;

    // The pair of carry-outs a select block computes ahead of its real carry
    typedef struct packed {
        logic if_one;
        logic if_zero;
    } carry_pair_t;

    // Width of block i
    function automatic int block_width(size_list_t lst, int i);
        return int'(lst[i*SZ_W +: SZ_W]);
    endfunction

    // Bit position where block i begins
    function automatic int block_base(size_list_t lst, int i);
        int acc;
        acc = 0;
        for (int k = 0; k < i; k++) begin
            acc += block_width(lst, k);
        end
        return acc;
    endfunction

    // Total width covered by the first n blocks
    function automatic int list_total(size_list_t lst, int n);
        return block_base(lst, n);
    endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);

    logic [W:0] c;

    assign c[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p;
        logic g;
        assign p      = x[i] ^ y[i];
        assign g      = x[i] & y[i];
        assign s[i]   = p ^ c[i];
        assign c[i+1] = g | (p & c[i]);
    end

    assign co = c[W];

endmodule

// File: rtl/csa_select_block.sv
module csa_select_block #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sel_c,
    output logic [W-1:0] s,
    output logic         co
);
    import csa_pkg::*;

    logic [W-1:0] s_zero;
    logic [W-1:0] s_one;
    carry_pair_t  cp;

    // Two chains computed in parallel, one per assumed carry-in
    csa_ripple #(.W(W)) u_assume0 (
        .x  (x),
        .y  (y),
        .ci (1'b0),
        .s  (s_zero),
        .co (cp.if_zero)
    );

    csa_ripple #(.W(W)) u_assume1 (
        .x  (x),
        .y  (y),
        .ci (1'b1),
        .s  (s_one),
        .co (cp.if_one)
    );

    // The real carry picks one of the two results
    always_comb begin
        if (sel_c) begin
            s  = s_one;
            co = cp.if_one;
        end else begin
            s  = s_zero;
            co = cp.if_zero;
        end
    end

endmodule

// File: rtl/csa_graded_adder.sv
module csa_graded_adder #(
    parameter int                  WIDTH       = 64,
    parameter int                  NUM_BLOCKS  = 7,
    parameter csa_pkg::size_list_t BLOCK_SIZES =
        csa_pkg::size_list_t'({8'd12, 8'd11, 8'd10, 8'd9, 8'd8, 8'd7, 8'd7})
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    import csa_pkg::*;

    localparam int COVERED = list_total(BLOCK_SIZES, NUM_BLOCKS);

    if (COVERED != WIDTH) begin : g_size_error
        $error("block sizes cover %0d bits, WIDTH is %0d", COVERED, WIDTH);
    end

    // carry[k] is the real carry entering block k
    logic [NUM_BLOCKS:0] carry;
    assign carry[0] = cin;

    for (genvar k = 0; k < NUM_BLOCKS; k++) begin : g_blk
        localparam int BW   = block_width(BLOCK_SIZES, k);
        localparam int BASE = block_base(BLOCK_SIZES, k);

        if (k == 0) begin : g_low
            csa_ripple #(.W(BW)) u_ripple (
                .x  (opa[BASE +: BW]),
                .y  (opb[BASE +: BW]),
                .ci (carry[k]),
                .s  (sum[BASE +: BW]),
                .co (carry[k+1])
            );
        end else begin : g_sel
            csa_select_block #(.W(BW)) u_sel (
                .x     (opa[BASE +: BW]),
                .y     (opb[BASE +: BW]),
                .sel_c (carry[k]),
                .s     (sum[BASE +: BW]),
                .co    (carry[k+1])
            );
        end
    end

    assign cout = carry[NUM_BLOCKS];

endmodule

// File: rtl/csa_graded_adder_chk.sv
module csa_graded_adder_chk #(
    parameter int                  WIDTH       = 64,
    parameter int                  NUM_BLOCKS  = 7,
    parameter csa_pkg::size_list_t BLOCK_SIZES = '0
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    import csa_pkg::*;

    logic [WIDTH:0] ref_total;
    logic [WIDTH-1:0] prop;

    assign ref_total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
    assign prop      = opa ^ opb;

    always_comb begin
        assert_sum_R1: assert (sum == ref_total[WIDTH-1:0])
            else $error("R1 sum mismatch");
        assert_cout_R2: assert (cout == ref_total[WIDTH])
            else $error("R2 carry-out mismatch");
        if (cin && (prop == {WIDTH{1'b1}})) begin
            assert_full_prop_R3: assert ((sum == '0) && cout)
                else $error("R3 full propagate failed");
        end
    end

    for (genvar k = 1; k < NUM_BLOCKS; k++) begin : g_bnd
        localparam int BASE = block_base(BLOCK_SIZES, k);
        always_comb begin
            if (cin && (prop[BASE-1:0] == {BASE{1'b1}})) begin
                assert_boundary_R4: assert (sum[BASE] == ~prop[BASE])
                    else $error("R4 boundary carry at bit %0d", BASE);
            end
        end
    end

endmodule

bind csa_graded_adder csa_graded_adder_chk #(
    .WIDTH       (WIDTH),
    .NUM_BLOCKS  (NUM_BLOCKS),
    .BLOCK_SIZES (BLOCK_SIZES)
) u_chk (
    .opa  (opa),
    .opb  (opb),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/test_csa_graded_adder.sv
`timescale 1ns/100ps
module test_csa_graded_adder;

    // 250 MHz clock, used for pacing and the watchdog
    logic clk = 1'b0;
    always #2 clk = ~clk;

    int n_vec  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // Default 64-bit configuration
    logic [63:0] a64, b64, s64;
    logic        c64, co64;

    csa_graded_adder i_csa_graded_adder (
        .opa (a64), .opb (b64), .cin (c64), .sum (s64), .cout (co64)
    );

    // Small configuration: 8 bits, blocks 2,3,3 from the bottom
    logic [7:0] a8, b8, s8;
    logic       c8, co8;

    csa_graded_adder #(
        .WIDTH       (8),
        .NUM_BLOCKS  (3),
        .BLOCK_SIZES (csa_pkg::size_list_t'({8'd3, 8'd3, 8'd2}))
    ) i_csa_graded_adder_small (
        .opa (a8), .opb (b8), .cin (c8), .sum (s8), .cout (co8)
    );

    task automatic check(string req, logic [64:0] act, logic [64:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!done && cyc >= 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    // Apply one 64-bit vector and check R1 and R2
    task automatic apply64(logic [63:0] a, logic [63:0] b, logic c);
        logic [64:0] e;
        a64 = a; b64 = b; c64 = c;
        #1;
        e = {1'b0, a} + {1'b0, b} + {64'd0, c};
        check("R1", {1'b0, s64}, {1'b0, e[63:0]});
        check("R2", {64'd0, co64}, {64'd0, e[64]});
    endtask

    initial begin
        logic [8:0]  prev8;
        logic [64:0] lo, hi;
        int          bases [6] = '{7, 14, 22, 31, 41, 52};

        a64 = '0; b64 = '0; c64 = 1'b0;
        a8  = '0; b8  = '0; c8  = 1'b0;
        #0.5;

        // Zero inputs give zero outputs
        #1;
        check("R1", {1'b0, s64}, 65'd0);
        check("R2", {64'd0, co64}, 65'd0);

        // R3: all ones plus carry-in, and complementary operands
        apply64('1, '0, 1'b1);
        check("R3", {co64, s64}, {1'b1, 64'd0});
        apply64(64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b1);
        check("R3", {co64, s64}, {1'b1, 64'd0});
        apply64('1, 64'd1, 1'b0);
        check("R3", {co64, s64}, {1'b1, 64'd0});

        // R4 and R5: propagate run below each block boundary, cin toggled
        foreach (bases[i]) begin
            int p = bases[i];
            logic [63:0] m = (64'd1 << p) - 64'd1;
            apply64(m, 64'd0, 1'b0);
            lo = {co64, s64};
            apply64(m, 64'd0, 1'b1);
            hi = {co64, s64};
            check("R4", {64'd0, s64[p]}, 65'd1);
            check("R5", hi, lo + 65'd1);
            // split ones between operands, upper bit set in one operand
            apply64(m & 64'h5555_5555_5555_5555 | (64'd1 << p),
                    m & 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
            check("R4", {64'd0, s64[p]}, 65'd0);
        end

        // Random 64-bit vectors
        for (int r = 0; r < 2000; r++) begin
            logic [63:0] ra = {$urandom, $urandom};
            logic [63:0] rb = {$urandom, $urandom};
            logic        rc = 1'($urandom);
            apply64(ra, rb, rc);
        end

        // Exhaustive sweep of the small configuration
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [8:0] e8;
                    a8 = 8'(i); b8 = 8'(j); c8 = 1'(c);
                    #1;
                    e8 = 9'(i) + 9'(j) + 9'(c);
                    check("R1", {57'd0, s8}, {57'd0, e8[7:0]});
                    check("R2", {64'd0, co8}, {64'd0, e8[8]});
                    if (c == 1) begin
                        check("R5", {56'd0, co8, s8}, {56'd0, prev8 + 9'd1});
                        if (i == 255 && j == 0)
                            check("R3", {56'd0, co8, s8}, {56'd0, 9'h100});
                        if (((i ^ j) & 3) == 3)
                            check("R4", {64'd0, s8[2]}, {64'd0, ~(a8[2] ^ b8[2])});
                        if (((i ^ j) & 31) == 31)
                            check("R4", {64'd0, s8[5]}, {64'd0, ~(a8[5] ^ b8[5])});
                    end else begin
                        prev8 = {co8, s8};
                    end
                end
            end
        end

        finish_run();
    end

endmodule